// File: doc/BRIEF.md
# Configuration Access Sequencer with Sub-Word Merge

This block sits between a host that issues configuration reads and writes of one, two or four bytes and a bridge register port that only handles full 32-bit transfers. The bridge port has one register that takes a configuration address and a second register that moves the data. A host request carries a bus number, a device/function number, a byte offset and a size. The sequencer validates the request and builds the configuration address. It then runs the address-then-data steps on the downstream port and returns the result through a one-cycle completion strobe.

Sub-word reads fetch the whole word and steer the addressed lanes down to the low bits of the result. Sub-word writes fetch the word, merge the new lanes in, then rewrite the address and store the whole word. Any nonzero bus number sets a marker bit so that a bridge further down the hierarchy forwards the access. A board-level select output drops while the sequence runs, so that a shared chip select reaches the bridge registers only for that span. A host-programmed cycle limit bounds every downstream phase. A read that runs out of time returns all ones instead of an error.

Top module: `cfg_access_seq`

## Requirements
- R1: `reqReady` is high only while the block is idle, so one request at a time is in flight. Every accepted request yields exactly one cycle of `doneValid`.
- R2: Every downstream access writes the address register (offset 0x500) first. The data register (offset 0x504) is then read or written.
- R3: The address written is bus<<16 | devfn<<8 | (offset & 0xFC). Bit 1 is always zero, and offset bits 1:0 never reach the port.
- R4: A nonzero bus number sets address bit 0 (forwarded access). Bus 0 leaves it clear.
- R5: A request with bus > 7 or devfn > 127 makes no downstream access and reports status 01. A rejected read returns ones at the requested width: 0x000000FF, 0x0000FFFF or 0xFFFFFFFF. A rejected write changes nothing.
- R6: A byte read uses byte index (offset XOR 3) & 3 in big-endian numbering of the word. Offset low bits 0,1,2,3 therefore return bits 7:0, 15:8, 23:16 and 31:24 in `doneData[7:0]`, with the upper bits zero.
- R7: A half-word read uses index ((offset XOR 2) >> 1) & 1. Offset bit 1 clear returns bits 15:0, and offset bit 1 set returns bits 31:16. Offset bit 0 is ignored.
- R8: `reqSize` 00 means byte, 01 means half-word, and 10 or 11 means full word. A word access moves all 32 bits unchanged.
- R9: A sub-word write runs four phases: address, data read, address, data write. The stored word is the fetched word with only the addressed lanes replaced, and the unused bits of `reqWdata` are ignored. A word write runs two phases: address, then data write.
- R10: A phase with no `dsAck` after `timeoutLimit` waiting cycles ends anyway. A read phase that ends this way yields 0xFFFFFFFF as the fetched word. An acknowledge in the same cycle that the limit is reached counts as a response.
- R11: `boardSel` rests high. It is low from the first downstream phase through the last, is low whenever `dsReq` is high, and never goes low for a rejected request.
- R12: `doneStatus` is 00 for every accepted request, including one that ran out of time. A write completes with `doneData` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeoutLimit | input | 16 | Waiting cycles allowed per downstream phase |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle, request accepted this cycle if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Bus number |
| reqDevFn | input | 8 | Device/function number |
| reqOffset | input | 8 | Byte offset in configuration space |
| reqSize | input | 2 | 00 byte, 01 half-word, 1x word |
| reqWdata | input | 32 | Write data, right-aligned |
| doneValid | output | 1 | One-cycle completion strobe |
| doneData | output | 32 | Read result, right-aligned |
| doneStatus | output | 2 | 00 success, 01 not found |
| dsReq | output | 1 | Downstream phase active |
| dsWrite | output | 1 | Downstream phase is a write |
| dsAddr | output | 12 | Bridge register offset of the phase |
| dsWdata | output | 32 | Downstream write data |
| dsAck | input | 1 | Downstream phase acknowledged |
| dsRdata | input | 32 | Downstream read data, valid with dsAck |
| boardSel | output | 1 | Low while the bridge registers are selected |

## Verification
The acknowledge of a downstream phase and the expiry of its wait limit can land on the same clock edge. The bench provokes this by setting the responder latency equal to `timeoutLimit`, then one cycle more, and also with a limit of zero. The verdict comes from the returned word: real data when the acknowledge shares the edge, all ones one cycle later. The limit also meets the merge sequence, in a byte write to an absent device whose fetch runs out of time. That case is judged by reading back the word that the merge then stored.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  localparam int WORD_W = 32;

  localparam logic [1:0] STAT_OK        = 2'b00;
  localparam logic [1:0] STAT_NOT_FOUND = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture a host request
    logic addrPhase;  // drive the configuration address downstream
    logic loadRd;     // capture acknowledged read data
    logic loadOnes;   // read phase ran out of time
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_RD,
    S_WR,
    S_DONE
  } seqState_t;

endpackage

// File: rtl/cfg_access_dp.sv
module cfg_access_dp
  import cfg_access_pkg::*;
#(
  parameter int BUS_MAX   = 7,
  parameter int DEVFN_MAX = 127
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic                reqWrite,
  input  logic [7:0]          reqBus,
  input  logic [7:0]          reqDevFn,
  input  logic [7:0]          reqOffset,
  input  logic [1:0]          reqSize,
  input  logic [WORD_W-1:0]   reqWdata,
  input  logic [WORD_W-1:0]   dsRdata,
  input  logic                doneValid,
  output logic                reqBad,
  output logic                isWrite,
  output logic                isSubWrite,
  output logic [WORD_W-1:0]   dsWdata,
  output logic [WORD_W-1:0]   doneData,
  output logic [1:0]          doneStatus
);

  logic              wrR, badR;
  logic [7:0]        busR, devFnR, offR;
  logic [1:0]        sizeR;
  logic [WORD_W-1:0] wdataR, wordBuf;

  logic [WORD_W-1:0] cfgAddr, fetched, laneMask, laneIns, merged, extracted, onesAtWidth;
  logic [1:0]        byteIdxBe, byteDiff;
  logic              halfIdxBe, halfDiff;
  logic [4:0]        byteSh, halfSh;

  assign reqBad = (32'(reqBus) > BUS_MAX) || (32'(reqDevFn) > DEVFN_MAX);

  assign isWrite    = wrR;
  assign isSubWrite = wrR && !sizeR[1];

  // configuration address: dword aligned, bit 0 marks a forwarded bus
  assign cfgAddr = {8'h00, busR, devFnR, offR[7:2], 1'b0, (busR != 8'h00)};

  // big-endian lane index, turned into a bit shift within the word
  assign byteIdxBe = offR[1:0] ^ 2'b11;
  assign byteDiff  = 2'd3 - byteIdxBe;
  assign byteSh    = {byteDiff, 3'b000};
  assign halfIdxBe = offR[1] ^ 1'b1;
  assign halfDiff  = 1'b1 - halfIdxBe;
  assign halfSh    = {halfDiff, 4'b0000};

  assign fetched = ctl.loadOnes ? {WORD_W{1'b1}} : dsRdata;

  always_comb begin
    if (sizeR[0]) begin
      laneMask = 32'h0000_FFFF << halfSh;
      laneIns  = {16'h0000, wdataR[15:0]} << halfSh;
    end else begin
      laneMask = 32'h0000_00FF << byteSh;
      laneIns  = {24'h000000, wdataR[7:0]} << byteSh;
    end
    merged = (fetched & ~laneMask) | laneIns;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrR     <= 1'b0;
      badR    <= 1'b0;
      busR    <= '0;
      devFnR  <= '0;
      offR    <= '0;
      sizeR   <= '0;
      wdataR  <= '0;
      wordBuf <= '0;
    end else if (ctl.loadReq) begin
      wrR     <= reqWrite;
      badR    <= reqBad;
      busR    <= reqBus;
      devFnR  <= reqDevFn;
      offR    <= reqOffset;
      sizeR   <= reqSize;
      wdataR  <= reqWdata;
      wordBuf <= reqBad ? {WORD_W{1'b1}} : reqWdata;
    end else if (ctl.loadRd || ctl.loadOnes) begin
      wordBuf <= isSubWrite ? merged : fetched;
    end
  end

  always_comb begin
    unique casez (sizeR)
      2'b00:   begin
                 extracted   = {24'h000000, 8'(wordBuf >> byteSh)};
                 onesAtWidth = 32'h0000_00FF;
               end
      2'b01:   begin
                 extracted   = {16'h0000, 16'(wordBuf >> halfSh)};
                 onesAtWidth = 32'h0000_FFFF;
               end
      default: begin
                 extracted   = wordBuf;
                 onesAtWidth = 32'hFFFF_FFFF;
               end
    endcase
  end

  assign doneData   = wrR ? '0 : extracted;
  assign doneStatus = badR ? STAT_NOT_FOUND : STAT_OK;
  assign dsWdata    = ctl.addrPhase ? cfgAddr : wordBuf;

  // R5: a rejected read hands back ones at the requested width
  a_r5_reject_ones: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && badR && !wrR) |-> (doneData == onesAtWidth));

  // R3: the address sent downstream is dword aligned
  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrPhase |-> (dsWdata[1] == 1'b0));

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int              TMO_W        = 16,
  parameter int              REG_AW       = 12,
  parameter logic [REG_AW-1:0] ADDR_REG_OFF = 12'h500,
  parameter logic [REG_AW-1:0] DATA_REG_OFF = 12'h504
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              reqValid,
  input  logic              reqBad,
  input  logic              isWrite,
  input  logic              isSubWrite,
  input  logic              dsAck,
  output logic              reqReady,
  output logic              dsReq,
  output logic              dsWrite,
  output logic [REG_AW-1:0] dsAddr,
  output logic              boardSel,
  output logic              doneValid,
  output dpCtl_t            ctl
);

  seqState_t        state, stateNext;
  logic             mergePass;
  logic [TMO_W-1:0] waitCnt;
  logic             expired, phaseEnd;

  assign dsReq     = (state == S_ADDR) || (state == S_RD) || (state == S_WR);
  assign dsWrite   = (state != S_RD);
  assign dsAddr    = (state == S_ADDR) ? ADDR_REG_OFF : DATA_REG_OFF;
  assign reqReady  = (state == S_IDLE);
  assign doneValid = (state == S_DONE);

  // acknowledge wins over an expiry on the same edge
  assign expired  = dsReq && !dsAck && (waitCnt >= timeoutLimit);
  assign phaseEnd = dsReq && (dsAck || expired);

  assign ctl.loadReq   = (state == S_IDLE) && reqValid;
  assign ctl.addrPhase = (state == S_ADDR);
  assign ctl.loadRd    = (state == S_RD) && dsAck;
  assign ctl.loadOnes  = (state == S_RD) && expired;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) stateNext = reqBad ? S_DONE : S_ADDR;
      S_ADDR: if (phaseEnd)
                stateNext = (isWrite && (!isSubWrite || mergePass)) ? S_WR : S_RD;
      S_RD:   if (phaseEnd) stateNext = isSubWrite ? S_ADDR : S_DONE;
      S_WR:   if (phaseEnd) stateNext = S_DONE;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      mergePass <= 1'b0;
      waitCnt   <= '0;
      boardSel  <= 1'b1;
    end else begin
      state <= stateNext;

      if (state == S_IDLE)
        mergePass <= 1'b0;
      else if (state == S_RD && phaseEnd && isSubWrite)
        mergePass <= 1'b1;

      if (!dsReq || phaseEnd)
        waitCnt <= '0;
      else if (waitCnt != {TMO_W{1'b1}})
        waitCnt <= waitCnt + 1'b1;

      if (state == S_IDLE && reqValid && !reqBad)
        boardSel <= 1'b0;
      else if (phaseEnd && stateNext == S_DONE)
        boardSel <= 1'b1;
    end
  end

  // R2: a run of downstream phases always opens with the address write
  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsReq) |-> (dsWrite && dsAddr == ADDR_REG_OFF));

  // R11: the bridge registers are selected whenever the port is busy
  a_r11_sel_low: assert property (@(posedge clk) disable iff (!rstN)
    dsReq |-> !boardSel);

  // R1: completion is a single cycle and never overlaps acceptance
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r1_done_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);

endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_access_pkg::*;
#(
  parameter int BUS_MAX   = 7,
  parameter int DEVFN_MAX = 127,
  parameter int TMO_W     = 16,
  parameter int REG_AW    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [7:0]        reqBus,
  input  logic [7:0]        reqDevFn,
  input  logic [7:0]        reqOffset,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              doneValid,
  output logic [31:0]       doneData,
  output logic [1:0]        doneStatus,
  output logic              dsReq,
  output logic              dsWrite,
  output logic [REG_AW-1:0] dsAddr,
  output logic [31:0]       dsWdata,
  input  logic              dsAck,
  input  logic [31:0]       dsRdata,
  output logic              boardSel
);

  localparam logic [REG_AW-1:0] ADDR_OFF = REG_AW'(12'h500);
  localparam logic [REG_AW-1:0] DATA_OFF = ADDR_OFF + REG_AW'(4);

  dpCtl_t ctl;
  logic   reqBad, isWrite, isSubWrite;

  cfg_access_ctrl #(
    .TMO_W(TMO_W), .REG_AW(REG_AW),
    .ADDR_REG_OFF(ADDR_OFF), .DATA_REG_OFF(DATA_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .timeoutLimit(timeoutLimit),
    .reqValid(reqValid), .reqBad(reqBad), .isWrite(isWrite),
    .isSubWrite(isSubWrite), .dsAck(dsAck), .reqReady(reqReady),
    .dsReq(dsReq), .dsWrite(dsWrite), .dsAddr(dsAddr),
    .boardSel(boardSel), .doneValid(doneValid), .ctl(ctl)
  );

  cfg_access_dp #(
    .BUS_MAX(BUS_MAX), .DEVFN_MAX(DEVFN_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .dsRdata(dsRdata),
    .doneValid(doneValid), .reqBad(reqBad), .isWrite(isWrite),
    .isSubWrite(isSubWrite), .dsWdata(dsWdata), .doneData(doneData),
    .doneStatus(doneStatus)
  );

endmodule

// File: tb/cfg_access_seq_tb.sv
`timescale 1ns/1ps
module cfg_access_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timeoutLimit = 16'd16;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqBus = '0, reqDevFn = '0, reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, doneValid, dsReq, dsWrite, boardSel;
  logic [31:0] doneData, dsWdata;
  logic [1:0]  doneStatus;
  logic [11:0] dsAddr;
  logic        dsAck = 1'b0;
  logic [31:0] dsRdata = '0;

  always #10 clk = ~clk;

  cfg_access_seq u_dut (
    .clk(clk), .rstN(rstN), .timeoutLimit(timeoutLimit),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevFn(reqDevFn), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .doneValid(doneValid),
    .doneData(doneData), .doneStatus(doneStatus), .dsReq(dsReq),
    .dsWrite(dsWrite), .dsAddr(dsAddr), .dsWdata(dsWdata),
    .dsAck(dsAck), .dsRdata(dsRdata), .boardSel(boardSel)
  );

  int total = 0, fails = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // downstream bridge model: address register, then data register
  logic [31:0] mem [logic [31:0]];
  int          latency = 2;
  logic [31:0] curAddr = '0, lastAddr = '0;
  int          phaseCnt = 0, waitCnt = 0, selLowCnt = 0, selErr = 0, doneCnt = 0;
  logic        prevReq = 1'b0, prevAcked = 1'b0, prevWr = 1'b0;
  logic [11:0] prevAddr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      logic newPhase;
      logic present;
      newPhase = !prevReq || prevAcked || (dsAddr != prevAddr) || (dsWrite != prevWr);
      dsAck = 1'b0;
      if (!boardSel) selLowCnt++;
      if (doneValid) doneCnt++;
      if (dsReq) begin
        if (boardSel) selErr++;
        if (newPhase) begin waitCnt = 0; phaseCnt++; end
        present = dsWrite || mem.exists(curAddr);
        if (present && waitCnt == latency) begin
          dsAck = 1'b1;
          if (dsAddr == 12'h500) begin curAddr = dsWdata; lastAddr = dsWdata; end
          else if (dsWrite) mem[curAddr] = dsWdata;
          else dsRdata = mem[curAddr];
        end else waitCnt++;
      end
      prevAcked = dsAck;
      prevReq   = dsReq;
      prevAddr  = dsAddr;
      prevWr    = dsWrite;
    end
  end

  logic [31:0] gotData;
  logic [1:0]  gotSt;
  logic        hung = 1'b0;

  task automatic doReq(input logic wr, input logic [7:0] bus, input logic [7:0] dfn,
                       input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd);
    int guard;
    @(negedge clk);
    phaseCnt = 0; selLowCnt = 0; doneCnt = 0; lastAddr = '0;
    reqValid = 1'b1; reqWrite = wr; reqBus = bus; reqDevFn = dfn;
    reqOffset = off; reqSize = sz; reqWdata = wd;
    guard = 0;
    while (!reqReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid && guard < 1000) begin @(negedge clk); guard++; end
    if (guard >= 1000) hung = 1'b1;
    gotData = doneData;
    gotSt   = doneStatus;
    @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [3:0]  tag;
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  dfn;
    logic [7:0]  off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] expData;
    logic [1:0]  expSt;
    logic [3:0]  expPh;
    logic [31:0] expAddr;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd8,  1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0, 32'h11223344, 2'b00, 4'd2, 32'h00000800}, // R8 R3
    '{4'd6,  1'b0, 8'h00, 8'h08, 8'h00, 2'b00, 32'h0, 32'h00000044, 2'b00, 4'd2, 32'h00000800}, // R6
    '{4'd6,  1'b0, 8'h00, 8'h08, 8'h03, 2'b00, 32'h0, 32'h00000011, 2'b00, 4'd2, 32'h00000800}, // R6
    '{4'd6,  1'b0, 8'h00, 8'h08, 8'h01, 2'b00, 32'h0, 32'h00000033, 2'b00, 4'd2, 32'h00000800}, // R6
    '{4'd7,  1'b0, 8'h00, 8'h08, 8'h00, 2'b01, 32'h0, 32'h00003344, 2'b00, 4'd2, 32'h00000800}, // R7
    '{4'd7,  1'b0, 8'h00, 8'h08, 8'h02, 2'b01, 32'h0, 32'h00001122, 2'b00, 4'd2, 32'h00000800}, // R7
    '{4'd7,  1'b0, 8'h00, 8'h08, 8'h03, 2'b01, 32'h0, 32'h00001122, 2'b00, 4'd2, 32'h00000800}, // R7 bit0 ignored
    '{4'd4,  1'b0, 8'h02, 8'h10, 8'h04, 2'b10, 32'h0, 32'hAABBCCDD, 2'b00, 4'd2, 32'h00021005}, // R4
    '{4'd4,  1'b0, 8'h02, 8'h10, 8'h06, 2'b00, 32'h0, 32'h000000BB, 2'b00, 4'd2, 32'h00021005}, // R4 R6
    '{4'd5,  1'b0, 8'h08, 8'h08, 8'h00, 2'b00, 32'h0, 32'h000000FF, 2'b01, 4'd0, 32'h0},        // R5 bus
    '{4'd5,  1'b0, 8'h00, 8'h80, 8'h00, 2'b01, 32'h0, 32'h0000FFFF, 2'b01, 4'd0, 32'h0},        // R5 devfn
    '{4'd10, 1'b0, 8'h07, 8'h7F, 8'h10, 2'b10, 32'h0, 32'hFFFFFFFF, 2'b00, 4'd2, 32'h00077F11}, // R10 R12
    '{4'd9,  1'b1, 8'h00, 8'h08, 8'h01, 2'b00, 32'hFFFFFF5A, 32'h0, 2'b00, 4'd4, 32'h00000800}, // R9
    '{4'd9,  1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0, 32'h11225A44, 2'b00, 4'd2, 32'h00000800}, // R9
    '{4'd9,  1'b1, 8'h00, 8'h08, 8'h02, 2'b01, 32'h1234BEEF, 32'h0, 2'b00, 4'd4, 32'h00000800}, // R9
    '{4'd9,  1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0, 32'hBEEF5A44, 2'b00, 4'd2, 32'h00000800}, // R9
    '{4'd8,  1'b1, 8'h02, 8'h10, 8'h04, 2'b10, 32'h01020304, 32'h0, 2'b00, 4'd2, 32'h00021005}, // R8 R9
    '{4'd8,  1'b0, 8'h02, 8'h10, 8'h04, 2'b10, 32'h0, 32'h01020304, 2'b00, 4'd2, 32'h00021005}, // R8
    '{4'd5,  1'b1, 8'h08, 8'h00, 8'h00, 2'b00, 32'h00000099, 32'h0, 2'b01, 4'd0, 32'h0},        // R5 write
    '{4'd5,  1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0, 32'hBEEF5A44, 2'b00, 4'd2, 32'h00000800}, // R5 no effect
    '{4'd10, 1'b1, 8'h07, 8'h7F, 8'h10, 2'b00, 32'h00000077, 32'h0, 2'b00, 4'd4, 32'h00077F11}, // R10 merge
    '{4'd10, 1'b0, 8'h07, 8'h7F, 8'h10, 2'b10, 32'h0, 32'hFFFFFF77, 2'b00, 4'd2, 32'h00077F11}, // R10
    '{4'd3,  1'b0, 8'h07, 8'h7F, 8'h13, 2'b10, 32'h0, 32'hFFFFFF77, 2'b00, 4'd2, 32'h00077F11}, // R3
    '{4'd8,  1'b0, 8'h00, 8'h08, 8'h00, 2'b11, 32'h0, 32'hBEEF5A44, 2'b00, 4'd2, 32'h00000800}  // R8 size 11
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    mem[32'h00000800] = 32'h11223344;
    mem[32'h00021005] = 32'hAABBCCDD;
    repeat (4) @(negedge clk);
    // R1 R11: reset state
    check("R1 reset reqReady", {31'b0, reqReady}, 32'd1);
    check("R1 reset doneValid", {31'b0, doneValid}, 32'd0);
    check("R11 reset boardSel", {31'b0, boardSel}, 32'd1);
    check("R2 reset dsReq", {31'b0, dsReq}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VECS[i].tag, i);
      doReq(VECS[i].wr, VECS[i].bus, VECS[i].dfn, VECS[i].off, VECS[i].sz, VECS[i].wd);
      check({t, " data"}, gotData, VECS[i].expData);
      check({t, " R12 status"}, {30'b0, gotSt}, {30'b0, VECS[i].expSt});
      check({t, " R2 R9 phases"}, phaseCnt, {28'b0, VECS[i].expPh});
      if (VECS[i].expPh != 0) check({t, " R3 R4 address"}, lastAddr, VECS[i].expAddr);
      check({t, " R11 select low span"}, {31'b0, selLowCnt > 0}, {31'b0, VECS[i].expPh != 0});
      check({t, " R1 one done pulse"}, doneCnt, 32'd1);
      check({t, " R1 idle after done"}, {31'b0, reqReady}, 32'd1);
    end
    check("R11 select never high during access", selErr, 32'd0);
    check("R9 stored merged word", mem[32'h00000800], 32'hBEEF5A44);

    // R10: acknowledge and expiry on the same edge, then one cycle late
    timeoutLimit = 16'd4; latency = 4;
    doReq(1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0);
    check("R10 ack on limit edge wins", gotData, 32'hBEEF5A44);
    latency = 5;
    doReq(1'b0, 8'h00, 8'h08, 8'h00, 2'b10, 32'h0);
    check("R10 ack one cycle late gives ones", gotData, 32'hFFFFFFFF);
    check("R12 status after expiry", {30'b0, gotSt}, 32'd0);
    timeoutLimit = 16'd0; latency = 0;
    doReq(1'b0, 8'h00, 8'h08, 8'h02, 2'b00, 32'h0);
    check("R10 zero limit immediate ack", gotData, 32'h000000EF);
    check("R1 no hang", {31'b0, hung}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule